// File: doc/BRIEF.md
# Branch Trace Buffer with Loop Compression

The block keeps a short history of taken branches. Each time the core reports a discontinuity, it presents a source address and a destination address on a strobe. If capture is allowed, the pair goes into a 16-slot circular store. When the store is full, the newest pair either replaces the oldest one or is refused with a one-cycle overflow-exception pulse. Branch events from hardware loops, events at the reset priority level and, in exception mode, events at the exception level or above are never stored.

Repeated loops are compressed. A new pair that equals the newest stored pair, ignoring bit 0, is not written again. Instead, bit 0 of that entry's destination is set. In two-level mode, a pair equal to the second-newest entry sets bit 0 of that entry's source. Software reads the store newest-first through a small register port. A status register gives the entry count. Each entry takes two reads of a data register: the destination first, then the source, and the second read removes the entry.

Top module: `branch_trace_buffer`

## Requirements
- R1: After reset the entry count is 0, the control register reads 0, a data-register read returns 0 and `ovfExc` is low.
- R2: A branch event is stored only when control bit 0 (power) and control bit 1 (enable) are both 1.
- R3: An event with `brHwLoop` high is never stored. An event with `brLevel` equal to 1 (reset level) is never stored.
- R4: When control bit 2 (overflow-exception) is 1, an event with `brLevel` of 3 or less is not stored. With bit 2 clear, such levels other than 1 are stored.
- R5: When the store holds 16 entries and control bit 2 is 1, an eligible event is dropped. `ovfExc` is high for exactly the one cycle that follows the event's clock edge.
- R6: When the store holds 16 entries and control bit 2 is 0, an eligible event discards the oldest entry, the new pair is stored and the count stays 16.
- R7: When control bits 4:3 are nonzero and at least one entry is present, an event equal to the newest entry (bit 0 of both addresses ignored) is not stored and sets bit 0 of that entry's destination. In mode 01, a pair equal only to the second-newest entry is stored normally.
- R8: When control bit 4 is 1 and at least two entries are present, an event equal to the second-newest entry (bit 0 ignored) that does not match the newest one sets bit 0 of that entry's source. If the event matches the newest entry, the newest-entry rule applies and the second-newest entry is unchanged.
- R9: A read at byte offset 0x004 returns the entry count, 0 to 16, in the low bits, with the upper bits 0.
- R10: A read at offset 0x100 with an empty store returns 0. Otherwise, the first read returns the newest destination and the next returns its source and removes that entry. The phase always restarts with a destination once the store is empty.
- R11: Writes at offset 0x000 set the 32-bit control register, which reads back unchanged. Writes at 0x004 or 0x100 change no state.
- R12: A branch event in the same cycle as a data-register read is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; data read takes effect at the clock edge |
| regAddr | input | 9 | Register byte offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid in the cycle `regRdEn` is high, 0 otherwise |
| brValid | input | 1 | Taken-branch event strobe |
| brSrc | input | 32 | Branch source address |
| brDst | input | 32 | Branch destination address |
| brHwLoop | input | 1 | Event is a hardware-loop return |
| brLevel | input | 4 | Current interrupt priority level (lower is higher priority) |
| ovfExc | output | 1 | Overflow-exception pulse |

## Verification
The hardest situation to reach is a full store while the overflow-exception bit is set. It needs sixteen distinct, eligible events, with compression off so that none merge, before the seventeenth event shows the pulse and the refusal. The stimulus fills the store twice, once with exception mode off and once with it on, and then drains it completely. The drain shows which pair was lost. Two other orderings are also set up deliberately. A pair is stored twice with compression off, so that the newest and second-newest entries are identical when two-level mode is switched on. A data read is issued in the same cycle as a branch event.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned DEPTH_LOG = 4;
  localparam int unsigned DEPTH     = 1 << DEPTH_LOG;
  localparam int unsigned CNT_W     = DEPTH_LOG + 1;
  localparam int unsigned REG_AW    = 9;

  localparam logic [REG_AW-1:0] OFS_CTL  = 9'h000;
  localparam logic [REG_AW-1:0] OFS_STAT = 9'h004;
  localparam logic [REG_AW-1:0] OFS_DATA = 9'h100;

  localparam int unsigned CTL_PWR  = 0;
  localparam int unsigned CTL_EN   = 1;
  localparam int unsigned CTL_OVFX = 2;
  localparam int unsigned CTL_CMP1 = 3;
  localparam int unsigned CTL_CMP2 = 4;

  typedef logic [DEPTH_LOG-1:0] slotIdx_t;

  typedef struct packed {
    logic     writeSlot;
    logic     markDst;
    logic     markSrc;
    slotIdx_t slotIdx;
    slotIdx_t newestIdx;
    slotIdx_t secondIdx;
  } storeCmd_t;
endpackage

// File: rtl/trace_store.sv
module trace_store
  import btb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  storeCmd_t         cmd,
  input  logic [DATA_W-1:0] evSrc,
  input  logic [DATA_W-1:0] evDst,
  output logic              hitNewest,
  output logic              hitSecond,
  output logic [DATA_W-1:0] newestSrc,
  output logic [DATA_W-1:0] newestDst
);
  logic [DATA_W-1:0] srcArr [DEPTH];
  logic [DATA_W-1:0] dstArr [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic [DATA_W-1:0] slotSrc;
    logic [DATA_W-1:0] slotDst;
    logic              selWrite;
    logic              selDst;
    logic              selSrc;

    assign selWrite = cmd.writeSlot && (cmd.slotIdx == slotIdx_t'(gi));
    assign selDst   = cmd.markDst && (cmd.newestIdx == slotIdx_t'(gi));
    assign selSrc   = cmd.markSrc && (cmd.secondIdx == slotIdx_t'(gi));

    always_ff @(posedge clk) begin
      if (selWrite) begin
        slotSrc <= evSrc;
        slotDst <= evDst;
      end else begin
        if (selDst) slotDst[0] <= 1'b1;
        if (selSrc) slotSrc[0] <= 1'b1;
      end
    end

    assign srcArr[gi] = slotSrc;
    assign dstArr[gi] = slotDst;
  end

  logic [DATA_W-1:0] secondSrc;
  logic [DATA_W-1:0] secondDst;

  assign newestSrc = srcArr[cmd.newestIdx];
  assign newestDst = dstArr[cmd.newestIdx];
  assign secondSrc = srcArr[cmd.secondIdx];
  assign secondDst = dstArr[cmd.secondIdx];

  assign hitNewest = (newestSrc[DATA_W-1:1] == evSrc[DATA_W-1:1]) &&
                     (newestDst[DATA_W-1:1] == evDst[DATA_W-1:1]);
  assign hitSecond = (secondSrc[DATA_W-1:1] == evSrc[DATA_W-1:1]) &&
                     (secondDst[DATA_W-1:1] == evDst[DATA_W-1:1]);
endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import btb_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LVL_W      = 4,
  parameter int unsigned LVL_RESET  = 1,
  parameter int unsigned LVL_EXCEPT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              brValid,
  input  logic              brHwLoop,
  input  logic [LVL_W-1:0]  brLevel,
  input  logic              hitNewest,
  input  logic              hitSecond,
  output storeCmd_t         cmd,
  output logic [DATA_W-1:0] ctlQ,
  output logic [CNT_W-1:0]  countQ,
  output slotIdx_t          topQ,
  output logic              midQ,
  output logic              ovfExc
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_TWO  = CNT_W'(2);

  logic dataRd;
  logic ctlWr;
  logic isFull;
  logic isEmpty;
  logic levelOk;
  logic eligible;
  logic ovfHit;
  logic cmp1On;
  logic cmp2On;
  logic doMarkDst;
  logic doMarkSrc;
  logic doWrite;

  assign dataRd  = regRdEn && (regAddr == OFS_DATA);
  assign ctlWr   = regWrEn && (regAddr == OFS_CTL);
  assign isFull  = (countQ == CNT_FULL);
  assign isEmpty = (countQ == '0);

  assign levelOk = (brLevel != LVL_W'(LVL_RESET)) &&
                   !(ctlQ[CTL_OVFX] && (brLevel <= LVL_W'(LVL_EXCEPT)));

  assign eligible = brValid && ctlQ[CTL_PWR] && ctlQ[CTL_EN] &&
                    !brHwLoop && levelOk && !dataRd;

  assign ovfHit = eligible && isFull && ctlQ[CTL_OVFX];

  assign cmp1On = ctlQ[CTL_CMP1] || ctlQ[CTL_CMP2];
  assign cmp2On = ctlQ[CTL_CMP2];

  assign doMarkDst = eligible && !ovfHit && cmp1On &&
                     (countQ >= CNT_ONE) && hitNewest;
  assign doMarkSrc = eligible && !ovfHit && !doMarkDst && cmp2On &&
                     (countQ >= CNT_TWO) && hitSecond;
  assign doWrite   = eligible && !ovfHit && !doMarkDst && !doMarkSrc;

  always_comb begin
    cmd.writeSlot = doWrite;
    cmd.markDst   = doMarkDst;
    cmd.markSrc   = doMarkSrc;
    cmd.slotIdx   = topQ;
    cmd.newestIdx = topQ - slotIdx_t'(1);
    cmd.secondIdx = topQ - slotIdx_t'(2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ <= '0;
    end else if (ctlWr) begin
      ctlQ <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      topQ   <= '0;
      midQ   <= 1'b0;
    end else if (dataRd && !isEmpty) begin
      if (midQ) begin
        topQ   <= topQ - slotIdx_t'(1);
        countQ <= countQ - CNT_ONE;
        midQ   <= 1'b0;
      end else begin
        midQ <= 1'b1;
      end
    end else begin
      if (doWrite) begin
        topQ <= topQ + slotIdx_t'(1);
        if (!isFull) countQ <= countQ + CNT_ONE;
      end
      if (isEmpty) midQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ovfExc <= 1'b0;
    else       ovfExc <= ovfHit;
  end
endmodule

// File: rtl/branch_trace_buffer.sv
module branch_trace_buffer
  import btb_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              brValid,
  input  logic [DATA_W-1:0] brSrc,
  input  logic [DATA_W-1:0] brDst,
  input  logic              brHwLoop,
  input  logic [LVL_W-1:0]  brLevel,
  output logic              ovfExc
);
  storeCmd_t         cmd;
  logic [DATA_W-1:0] ctlQ;
  logic [CNT_W-1:0]  countQ;
  slotIdx_t          topQ;
  logic              midQ;
  logic              hitNewest;
  logic              hitSecond;
  logic [DATA_W-1:0] newestSrc;
  logic [DATA_W-1:0] newestDst;

  trace_ctrl #(
    .DATA_W(DATA_W),
    .LVL_W (LVL_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .brValid  (brValid),
    .brHwLoop (brHwLoop),
    .brLevel  (brLevel),
    .hitNewest(hitNewest),
    .hitSecond(hitSecond),
    .cmd      (cmd),
    .ctlQ     (ctlQ),
    .countQ   (countQ),
    .topQ     (topQ),
    .midQ     (midQ),
    .ovfExc   (ovfExc)
  );

  trace_store #(
    .DATA_W(DATA_W)
  ) i_store (
    .clk      (clk),
    .cmd      (cmd),
    .evSrc    (brSrc),
    .evDst    (brDst),
    .hitNewest(hitNewest),
    .hitSecond(hitSecond),
    .newestSrc(newestSrc),
    .newestDst(newestDst)
  );

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      case (regAddr)
        OFS_CTL:  regRdData = ctlQ;
        OFS_STAT: regRdData = DATA_W'(countQ);
        OFS_DATA: begin
          if (countQ != '0) regRdData = midQ ? newestSrc : newestDst;
        end
        default:  regRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/trace_checks.sv
module trace_checks
  import btb_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LVL_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [DATA_W-1:0] regRdData,
  input logic              brValid,
  input logic              brHwLoop,
  input logic [LVL_W-1:0]  brLevel,
  input logic              ovfExc,
  input logic [DATA_W-1:0] ctlQ,
  input logic [CNT_W-1:0]  countQ,
  input slotIdx_t          topQ,
  input logic              midQ
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_FULL); // R9

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && !(ctlQ[CTL_PWR] && ctlQ[CTL_EN]) && !regRdEn)
    |=> ($stable(countQ) && $stable(topQ))); // R2

  AST_HWLOOP_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && brHwLoop && !regRdEn) |=> ($stable(countQ) && $stable(topQ))); // R3

  AST_RESET_LEVEL_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && brLevel == LVL_W'(1) && !regRdEn)
    |=> ($stable(countQ) && $stable(topQ))); // R3

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    ovfExc |-> $past(brValid && ctlQ[CTL_OVFX] && countQ == CNT_FULL)); // R5

  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == CNT_FULL && brValid && !regRdEn) |=> countQ == CNT_FULL); // R6

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == OFS_DATA && countQ == '0) |-> regRdData == '0); // R10

  AST_PHASE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == '0) |-> !midQ); // R10

  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr != OFS_CTL && !brValid && !regRdEn)
    |=> ($stable(countQ) && $stable(ctlQ) && $stable(midQ))); // R11

  AST_COINCIDENT_READ: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && regRdEn && regAddr == OFS_DATA) |=> countQ <= $past(countQ)); // R12
endmodule

bind branch_trace_buffer trace_checks #(
  .DATA_W(DATA_W),
  .LVL_W (LVL_W)
) i_trace_checks (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regRdEn  (regRdEn),
  .regAddr  (regAddr),
  .regRdData(regRdData),
  .brValid  (brValid),
  .brHwLoop (brHwLoop),
  .brLevel  (brLevel),
  .ovfExc   (ovfExc),
  .ctlQ     (ctlQ),
  .countQ   (countQ),
  .topQ     (topQ),
  .midQ     (midQ)
);

// File: tb/test_branch_trace_buffer.sv
module test_branch_trace_buffer;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] A_CTL  = 9'h000;
  localparam logic [8:0] A_STAT = 9'h004;
  localparam logic [8:0] A_DATA = 9'h100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [8:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        brValid = 1'b0;
  logic [31:0] brSrc = '0;
  logic [31:0] brDst = '0;
  logic        brHwLoop = 1'b0;
  logic [3:0]  brLevel = 4'd6;
  logic        ovfExc;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_trace_buffer i_branch_trace_buffer (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .brValid  (brValid),
    .brSrc    (brSrc),
    .brDst    (brDst),
    .brHwLoop (brHwLoop),
    .brLevel  (brLevel),
    .ovfExc   (ovfExc)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wrReg(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [8:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic branch(input logic [31:0] s, input logic [31:0] d,
                        input bit hw, input logic [3:0] lvl);
    @(negedge clk);
    brValid = 1'b1; brSrc = s; brDst = d; brHwLoop = hw; brLevel = lvl;
    @(negedge clk);
    brValid = 1'b0; brHwLoop = 1'b0; brLevel = 4'd6;
  endtask

  task automatic rdWithBranch(input logic [31:0] exp, input string tag,
                              input logic [31:0] s, input logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = A_DATA;
    brValid = 1'b1; brSrc = s; brDst = d;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    regRdEn = 1'b0; brValid = 1'b0;
  endtask

  task automatic checkOvf(input logic exp, input string tag);
    #(CLK_PERIOD/4);
    check(ovfExc === exp, tag, {31'b0, ovfExc}, {31'b0, exp});
  endtask

  // monitor: pops one expected item per read cycle
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (regRdEn) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R10 unexpected read", regRdData, 32'h0);
        end else begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(regRdData === e, t, regRdData, e);
        end
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R1 watchdog: got running expected done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkOvf(1'b0, "R1 ovfExc after reset");
    rdReg(A_STAT, 32'h0, "R1 count after reset");
    rdReg(A_CTL, 32'h0, "R1 control after reset");
    rdReg(A_DATA, 32'h0, "R1 data after reset");

    // R2 capture gating
    branch(32'h100, 32'h200, 1'b0, 4'd6);
    rdReg(A_STAT, 32'h0, "R2 unpowered");
    wrReg(A_CTL, 32'h2);
    branch(32'h100, 32'h200, 1'b0, 4'd6);
    rdReg(A_STAT, 32'h0, "R2 enable only");
    wrReg(A_CTL, 32'h1);
    branch(32'h100, 32'h200, 1'b0, 4'd6);
    rdReg(A_STAT, 32'h0, "R2 power only");
    wrReg(A_CTL, 32'h3);
    branch(32'h1000, 32'h2000, 1'b0, 4'd6);
    rdReg(A_STAT, 32'h1, "R2 powered and enabled");

    // R3 hardware loop and reset level
    branch(32'h1010, 32'h2010, 1'b1, 4'd6);
    rdReg(A_STAT, 32'h1, "R3 hardware loop");
    branch(32'h1020, 32'h2020, 1'b0, 4'd1);
    rdReg(A_STAT, 32'h1, "R3 reset level");

    // R4 level filter in exception mode
    branch(32'h1100, 32'h2100, 1'b0, 4'd3);
    rdReg(A_STAT, 32'h2, "R4 level 3 stored with bit 2 clear");
    wrReg(A_CTL, 32'h7);
    branch(32'h1200, 32'h2200, 1'b0, 4'd2);
    branch(32'h1210, 32'h2210, 1'b0, 4'd3);
    rdReg(A_STAT, 32'h2, "R4 levels 2 and 3 dropped");
    branch(32'h1300, 32'h2300, 1'b0, 4'd4);
    rdReg(A_STAT, 32'h3, "R4 level 4 stored");

    // R10 LIFO read order
    rdReg(A_DATA, 32'h2300, "R10 newest dst");
    rdReg(A_DATA, 32'h1300, "R10 newest src");
    rdReg(A_STAT, 32'h2, "R10 entry removed");
    rdReg(A_DATA, 32'h2100, "R10 second dst");
    rdReg(A_DATA, 32'h1100, "R10 second src");
    rdReg(A_DATA, 32'h2000, "R10 third dst");
    rdReg(A_DATA, 32'h1000, "R10 third src");
    rdReg(A_STAT, 32'h0, "R10 empty count");
    rdReg(A_DATA, 32'h0, "R10 empty data");

    // R11 only control writable
    wrReg(A_STAT, 32'h1F);
    wrReg(A_DATA, 32'h1F);
    rdReg(A_STAT, 32'h0, "R11 status write ignored");
    rdReg(A_CTL, 32'h7, "R11 control kept");
    wrReg(A_CTL, 32'hA5A5_0003);
    rdReg(A_CTL, 32'hA5A5_0003, "R11 control readback");

    // R6 overwrite oldest when full, bit 2 clear
    wrReg(A_CTL, 32'h3);
    for (int i = 0; i <= 16; i++)
      branch(32'h4000 + 32'(i * 16), 32'h8000 + 32'(i * 16), 1'b0, 4'd6);
    checkOvf(1'b0, "R6 no exception when overwriting");
    rdReg(A_STAT, 32'h10, "R6 count stays 16");
    for (int i = 16; i >= 1; i--) begin
      rdReg(A_DATA, 32'h8000 + 32'(i * 16), "R6 drain dst");
      rdReg(A_DATA, 32'h4000 + 32'(i * 16), "R6 drain src");
    end
    rdReg(A_STAT, 32'h0, "R6 oldest was discarded");

    // R5 overflow exception when full, bit 2 set
    wrReg(A_CTL, 32'h7);
    for (int i = 0; i < 16; i++)
      branch(32'h4000 + 32'(i * 16), 32'h8000 + 32'(i * 16), 1'b0, 4'd6);
    rdReg(A_STAT, 32'h10, "R9 count saturates at 16");
    branch(32'h4100, 32'h8100, 1'b0, 4'd6);
    checkOvf(1'b1, "R5 exception pulse");
    @(negedge clk);
    checkOvf(1'b0, "R5 pulse lasts one cycle");
    rdReg(A_STAT, 32'h10, "R5 count unchanged");
    for (int i = 15; i >= 0; i--) begin
      rdReg(A_DATA, 32'h8000 + 32'(i * 16), "R5 drain dst");
      rdReg(A_DATA, 32'h4000 + 32'(i * 16), "R5 drain src");
    end
    rdReg(A_STAT, 32'h0, "R5 drained");

    // R7 single-level compression
    wrReg(A_CTL, 32'h0B);
    branch(32'h500, 32'h600, 1'b0, 4'd6);
    branch(32'h500, 32'h600, 1'b0, 4'd6);
    branch(32'h501, 32'h600, 1'b0, 4'd6);
    rdReg(A_STAT, 32'h1, "R7 repeats merged");
    rdReg(A_DATA, 32'h601, "R7 dst bit 0 tagged");
    rdReg(A_DATA, 32'h500, "R7 src untouched");
    branch(32'h500, 32'h600, 1'b0, 4'd6);
    branch(32'h510, 32'h610, 1'b0, 4'd6);
    branch(32'h500, 32'h600, 1'b0, 4'd6);
    rdReg(A_STAT, 32'h3, "R7 no two-level in mode 01");
    rdReg(A_DATA, 32'h600, "R7 drain");
    rdReg(A_DATA, 32'h500, "R7 drain");
    rdReg(A_DATA, 32'h610, "R7 drain");
    rdReg(A_DATA, 32'h510, "R7 drain");
    rdReg(A_DATA, 32'h600, "R7 drain");
    rdReg(A_DATA, 32'h500, "R7 drain");

    // R8 two-level compression
    wrReg(A_CTL, 32'h13);
    branch(32'h700, 32'h800, 1'b0, 4'd6);
    branch(32'h900, 32'hA00, 1'b0, 4'd6);
    branch(32'h700, 32'h800, 1'b0, 4'd6);
    branch(32'h900, 32'hA00, 1'b0, 4'd6);
    rdReg(A_STAT, 32'h2, "R8 two-level merge");
    rdReg(A_DATA, 32'hA01, "R8 newest dst tagged");
    rdReg(A_DATA, 32'h900, "R8 newest src");
    rdReg(A_DATA, 32'h800, "R8 second dst");
    rdReg(A_DATA, 32'h701, "R8 second src tagged");

    // R8 priority of newest-entry rule
    wrReg(A_CTL, 32'h3);
    branch(32'hB00, 32'hC00, 1'b0, 4'd6);
    branch(32'hB00, 32'hC00, 1'b0, 4'd6);
    wrReg(A_CTL, 32'h13);
    branch(32'hB00, 32'hC00, 1'b0, 4'd6);
    rdReg(A_STAT, 32'h2, "R8 priority count");
    rdReg(A_DATA, 32'hC01, "R8 priority newest dst");
    rdReg(A_DATA, 32'hB00, "R8 priority newest src");
    rdReg(A_DATA, 32'hC00, "R8 priority second dst");
    rdReg(A_DATA, 32'hB00, "R8 priority second src untouched");

    // R12 read and branch together
    wrReg(A_CTL, 32'h3);
    branch(32'hD00, 32'hE00, 1'b0, 4'd6);
    rdWithBranch(32'hE00, "R12 read during branch", 32'hF00, 32'hF10);
    rdReg(A_STAT, 32'h1, "R12 branch not stored");
    rdReg(A_DATA, 32'hD00, "R12 src");
    rdReg(A_STAT, 32'h0, "R12 empty");
    rdReg(A_DATA, 32'h0, "R10 phase restarted");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) check(1'b0, "R10 pending reads", 32'(expQ.size()), 32'h0);
    finish();
  end
endmodule